// File: doc/BRIEF.md
# DMA Interrupt Status and Error Classifier

This block collects per-channel event pulses from a multi-channel DMA engine and keeps them as sticky flags in two status registers. One register holds the completion flags in its lower half and the per-channel interrupt enables in its upper half. The other register holds termination flags in its lower half and bus-error flags in its upper half. Each register can be reached at three addresses: a plain write replaces the contents, a set alias ORs the written mask in, and a clear alias removes exactly the masked bits. Software clears the flags it has read.

From the stored flags the block derives a qualified error vector. A termination counts as an error only when it comes with a bus error, or when it has no matching completion. It also drives a single interrupt line and a priority report. The report concatenates the errors above the completions and names the highest set position, so the host can service channels one at a time with every error ahead of every completion.

Top module: `dma_irq_classifier`

## Requirements
- R1: After reset both status registers, the error vector and the pending report are all zero, and `irq` is low.
- R2: A pulse on `ev_done[i]` sets completion bit i of register A. A pulse on `ev_term[i]` sets bit i of register B, and a pulse on `ev_buserr[i]` sets bit NCH+i of register B. Each flag stays set until software clears it. Hardware never sets an enable bit.
- R3: A write to the clear alias (register base + 8) clears exactly the bits that are 1 in the written mask and leaves all other bits unchanged.
- R4: A write to the set alias (base + 4) ORs the mask into the register. A write to the base address replaces the whole register. Register A is based at 0x00 and register B at 0x10.
- R5: A read at the base, the set alias or the clear alias returns that register's current value. A read at 0x20 returns the pending vector {errors, completions}. Any other address reads as zero.
- R6: The error for channel i is (buserr[i] AND term[i]) OR (term[i] AND NOT buserr[i] AND NOT done[i]). A termination that coincides with a completion and has no bus error is not an error.
- R7: `irq` is high exactly when some channel has both its completion flag and its enable set, or when any qualified error is present. Errors raise `irq` whatever the enable says.
- R8: `pend_valid` is high when the pending vector is non-zero. `pend_idx` then gives the position of its highest set bit (0 when nothing is pending). Positions NCH and above are errors of channel idx-NCH, and `pend_is_err` marks them. Completions appear in the pending vector whether or not they are enabled.
- R9: When a hardware event sets a flag in the same cycle that a host write clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address for read and write |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| ev_done | input | 16 | Per-channel completion event pulses |
| ev_term | input | 16 | Per-channel termination event pulses |
| ev_buserr | input | 16 | Per-channel bus-error event pulses |
| irq | output | 1 | Combined interrupt request |
| err_vec | output | 16 | Qualified per-channel error vector |
| pend_valid | output | 1 | Some error or completion is pending |
| pend_is_err | output | 1 | The reported pending item is an error |
| pend_idx | output | 5 | Highest set position of the pending vector |

## Verification
The assertions assume that event inputs and the write strobe are clean single-cycle levels that are sampled at the clock edge. The clear-alias property also assumes that the only thing that can re-set a cleared completion bit in the same cycle is a completion event. The bench changes every input only at the falling edge and holds it for exactly one cycle. It combines writes and events in one cycle only in the deliberate collision cases, so each check sees a single cause. The bench issues no write to register A's plain address while testing clears, and this keeps the clear-alias property meaningful.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;
   localparam int OFS_SET = 4;
   localparam int OFS_CLR = 8;
   localparam logic [7:0] DEF_BASE_A   = 8'h00;
   localparam logic [7:0] DEF_BASE_B   = 8'h10;
   localparam logic [7:0] DEF_PEND_ADR = 8'h20;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_WRITE,
      ACC_SET,
      ACC_CLR
   } acc_e;
endpackage

// File: rtl/dma_flag_reg.sv
`timescale 1ns/1ps
module dma_flag_reg
   import dma_irq_pkg::*;
#(
   parameter int          W    = 32,
   parameter int          AW   = 8,
   parameter logic [AW-1:0] BASE = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   input  logic [W-1:0]  hw_set,
   output logic [W-1:0]  q,
   output logic          hit
);
   localparam logic [AW-1:0] ADR_SET = BASE + AW'(OFS_SET);
   localparam logic [AW-1:0] ADR_CLR = BASE + AW'(OFS_CLR);

   acc_e         acc;
   logic [W-1:0] q_host;

   always_comb begin
      hit = (addr == BASE) || (addr == ADR_SET) || (addr == ADR_CLR);
      acc = ACC_NONE;
      if (wr) begin
         if (addr == BASE)         acc = ACC_WRITE;
         else if (addr == ADR_SET) acc = ACC_SET;
         else if (addr == ADR_CLR) acc = ACC_CLR;
      end
   end

   always_comb begin
      unique case (acc)
         ACC_WRITE: q_host = wdata;
         ACC_SET:   q_host = q | wdata;
         ACC_CLR:   q_host = q & ~wdata;
         default:   q_host = q;
      endcase
   end

   // hardware events win over a same-cycle host clear
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_host | hw_set;
   end
endmodule

// File: rtl/dma_err_qual.sv
`timescale 1ns/1ps
module dma_err_qual #(
   parameter int NCH = 16
) (
   input  logic [NCH-1:0] done,
   input  logic [NCH-1:0] term,
   input  logic [NCH-1:0] buserr,
   output logic [NCH-1:0] err
);
   for (genvar i = 0; i < NCH; i++) begin : g_lane
      logic bus_fault;
      logic lone_term;
      assign bus_fault = buserr[i] & term[i];
      assign lone_term = term[i] & ~buserr[i] & ~done[i];
      assign err[i]    = bus_fault | lone_term;
   end
endmodule

// File: rtl/dma_pend_prio.sv
`timescale 1ns/1ps
module dma_pend_prio #(
   parameter int W  = 32,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          valid,
   output logic [IW-1:0] idx
);
   always_comb begin
      valid = |vec;
      idx   = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/dma_irq_classifier.sv
`timescale 1ns/1ps
module dma_irq_classifier
   import dma_irq_pkg::*;
#(
   parameter int            NCH      = 16,
   parameter int            AW       = 8,
   parameter logic [AW-1:0] BASE_A   = DEF_BASE_A,
   parameter logic [AW-1:0] BASE_B   = DEF_BASE_B,
   parameter logic [AW-1:0] PEND_ADR = DEF_PEND_ADR,
   localparam int           DW       = 2 * NCH,
   localparam int           IW       = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [NCH-1:0] ev_done,
   input  logic [NCH-1:0] ev_term,
   input  logic [NCH-1:0] ev_buserr,
   output logic          irq,
   output logic [NCH-1:0] err_vec,
   output logic          pend_valid,
   output logic          pend_is_err,
   output logic [IW-1:0] pend_idx
);
   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("dma_irq_classifier: NCH must lie in 1..32");
   end
   if (AW < 5) begin : g_bad_aw
      $error("dma_irq_classifier: AW too narrow for the register map");
   end

   logic [DW-1:0]  reg_a_q, reg_b_q;
   logic           hit_a, hit_b;
   logic [NCH-1:0] done_q, en_q, term_q, berr_q;
   logic [DW-1:0]  pend_vec;

   dma_flag_reg #(.W(DW), .AW(AW), .BASE(BASE_A)) u_reg_a (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .hw_set ({{NCH{1'b0}}, ev_done}),
      .q      (reg_a_q),
      .hit    (hit_a)
   );

   dma_flag_reg #(.W(DW), .AW(AW), .BASE(BASE_B)) u_reg_b (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .hw_set ({ev_buserr, ev_term}),
      .q      (reg_b_q),
      .hit    (hit_b)
   );

   assign done_q = reg_a_q[NCH-1:0];
   assign en_q   = reg_a_q[DW-1:NCH];
   assign term_q = reg_b_q[NCH-1:0];
   assign berr_q = reg_b_q[DW-1:NCH];

   dma_err_qual #(.NCH(NCH)) u_qual (
      .done   (done_q),
      .term   (term_q),
      .buserr (berr_q),
      .err    (err_vec)
   );

   assign pend_vec = {err_vec, done_q};

   dma_pend_prio #(.W(DW), .IW(IW)) u_prio (
      .vec   (pend_vec),
      .valid (pend_valid),
      .idx   (pend_idx)
   );

   assign pend_is_err = pend_valid && (pend_idx >= IW'(NCH));
   assign irq         = (|(done_q & en_q)) | (|err_vec);

   always_comb begin
      if (hit_a)                      bus_rdata = reg_a_q;
      else if (hit_b)                 bus_rdata = reg_b_q;
      else if (bus_addr == PEND_ADR)  bus_rdata = pend_vec;
      else                            bus_rdata = '0;
   end
endmodule

// File: rtl/dma_irq_classifier_chk.sv
`timescale 1ns/1ps
module dma_irq_classifier_chk
   import dma_irq_pkg::*;
#(
   parameter int            NCH    = 16,
   parameter int            AW     = 8,
   parameter logic [AW-1:0] BASE_A = DEF_BASE_A,
   localparam int           DW     = 2 * NCH
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bus_wr,
   input logic [AW-1:0]  bus_addr,
   input logic [DW-1:0]  bus_wdata,
   input logic [NCH-1:0] ev_done,
   input logic [DW-1:0]  reg_a_q,
   input logic [DW-1:0]  reg_b_q,
   input logic           irq,
   input logic [NCH-1:0] err_vec,
   input logic           pend_valid,
   input logic           pend_is_err
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R6: completion alongside a plain termination hides the error
   a_r6_done_masks_term: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_vec & reg_b_q[NCH-1:0] & reg_a_q[NCH-1:0] & ~reg_b_q[DW-1:NCH]) == '0));

   // R6: termination with bus error is always an error
   a_r6_buserr_term: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_b_q[NCH-1:0] & reg_b_q[DW-1:NCH] & ~err_vec) == '0));

   // R7: any qualified error raises the interrupt
   a_r7_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_vec) |-> irq);

   // R8: interrupt implies something pending; errors reported first
   a_r8_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pend_valid);
   a_r8_err_first: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_vec) |-> (pend_valid && pend_is_err));

   // R9: a completion event always leaves its flag set
   a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (|ev_done) |=> ((reg_a_q[NCH-1:0] & $past(ev_done)) == $past(ev_done)));

   // R3: clear alias removes masked bits not re-set by an event
   a_r3_clear_alias: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (bus_wr && bus_addr == (BASE_A + AW'(OFS_CLR)))
      |=> ((reg_a_q & $past(bus_wdata & ~{{NCH{1'b0}}, ev_done})) == '0));
endmodule

bind dma_irq_classifier dma_irq_classifier_chk #(
   .NCH(NCH), .AW(AW), .BASE_A(BASE_A)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .ev_done     (ev_done),
   .reg_a_q     (reg_a_q),
   .reg_b_q     (reg_b_q),
   .irq         (irq),
   .err_vec     (err_vec),
   .pend_valid  (pend_valid),
   .pend_is_err (pend_is_err)
);

// File: tb/dma_irq_classifier_tb_top.sv
`timescale 1ns/1ps
module dma_irq_classifier_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [15:0] ev_done, ev_term, ev_buserr;
   logic        irq;
   logic [15:0] err_vec;
   logic        pend_valid, pend_is_err;
   logic [4:0]  pend_idx;

   always #2 clk = ~clk;

   dma_irq_classifier dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_done(ev_done),
      .ev_term(ev_term), .ev_buserr(ev_buserr), .irq(irq), .err_vec(err_vec),
      .pend_valid(pend_valid), .pend_is_err(pend_is_err), .pend_idx(pend_idx)
   );

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;

   logic [31:0] m_a = '0;
   logic [31:0] m_b = '0;

   function automatic logic [15:0] m_err();
      logic [15:0] d, t, b;
      d = m_a[15:0]; t = m_b[15:0]; b = m_b[31:16];
      return (b & t) | (t & ~b & ~d);
   endfunction

   function automatic logic m_irq();
      return (|(m_a[15:0] & m_a[31:16])) | (|m_err());
   endfunction

   function automatic logic [31:0] m_pend();
      logic [31:0] v;
      int hi;
      v  = {m_err(), m_a[15:0]};
      hi = -1;
      for (int i = 0; i < 32; i++) if (v[i]) hi = i;
      if (hi < 0) return 32'd0;
      return {25'd0, 1'b1, (hi >= 16), 5'(hi)};
   endfunction

   task automatic push(input int kind, input logic [31:0] exp, input string tag);
      item_t it;
      it.kind = kind; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic expect_state(input string tag);
      push(1, {31'd0, m_irq()}, tag);
      push(2, {16'd0, m_err()}, tag);
      push(3, m_pend(), tag);
   endtask

   task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      push(0, exp, tag);
      @(negedge clk);
   endtask

   task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] dn, input logic [15:0] tm, input logic [15:0] be);
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      ev_done = dn; ev_term = tm; ev_buserr = be;
      @(negedge clk);
      bus_wr = 1'b0; ev_done = '0; ev_term = '0; ev_buserr = '0;
      if (wr) begin
         case (a)
            8'h00: m_a = d;
            8'h04: m_a = m_a | d;
            8'h08: m_a = m_a & ~d;
            8'h10: m_b = d;
            8'h14: m_b = m_b | d;
            8'h18: m_b = m_b & ~d;
            default: ;
         endcase
      end
      m_a = m_a | {16'd0, dn};
      m_b = m_b | {be, tm};
   endtask

   // monitor: compare queued expectations against the outputs
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
               0: act = bus_rdata;
               1: act = {31'd0, irq};
               2: act = {16'd0, err_vec};
               default: act = {25'd0, pend_valid, pend_is_err, pend_idx};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      ev_done = '0; ev_term = '0; ev_buserr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_state("R1 reset outputs");
      read_chk(8'h00, 32'h0, "R1 reg A reset");
      read_chk(8'h10, 32'h0, "R1 reg B reset");
      read_chk(8'h20, 32'h0, "R1 pending reset");

      // R4 set alias enables all channels; R5 aliases read back
      step(1, 8'h04, 32'hFFFF_0000, '0, '0, '0);
      expect_state("R4 enables set");
      read_chk(8'h00, 32'hFFFF_0000, "R4 reg A after set alias");
      read_chk(8'h08, 32'hFFFF_0000, "R5 read at clear alias");
      read_chk(8'h04, 32'hFFFF_0000, "R5 read at set alias");

      // R2/R7/R8 completion on channel 3, then 10
      step(0, 8'h00, '0, 16'h0008, '0, '0);
      expect_state("R2 R7 done ch3");
      step(0, 8'h00, '0, 16'h0400, '0, '0);
      expect_state("R8 highest completion ch10");
      read_chk(8'h00, 32'hFFFF_0408, "R2 completion flags sticky");

      // R3 clear alias removes only bit 10
      step(1, 8'h08, 32'h0000_0400, '0, '0, '0);
      expect_state("R3 clear ch10");
      read_chk(8'h00, 32'hFFFF_0008, "R3 reg A after clear");

      // R6 lone termination ch5 is an error; R8 error before completion
      step(0, 8'h00, '0, '0, 16'h0020, '0);
      expect_state("R6 R8 lone term ch5");
      // R6 termination ch3 coincides with completion ch3: not an error
      step(0, 8'h00, '0, '0, 16'h0008, '0);
      expect_state("R6 term with done ch3");
      // R6 bus error on ch3 makes it an error
      step(0, 8'h00, '0, '0, '0, 16'h0008);
      expect_state("R6 buserr ch3");
      read_chk(8'h10, 32'h0008_0028, "R2 reg B flags");
      read_chk(8'h20, 32'h0028_0008, "R5 pending vector");

      // R3 clear everything pending
      step(1, 8'h18, 32'hFFFF_FFFF, '0, '0, '0);
      step(1, 8'h08, 32'h0000_FFFF, '0, '0, '0);
      expect_state("R3 all cleared");
      read_chk(8'h00, 32'hFFFF_0000, "R3 enables kept");

      // R8/R7 disabled completion ch7: pending but no irq
      step(1, 8'h08, 32'h0080_0000, '0, '0, '0);
      step(0, 8'h00, '0, 16'h0080, '0, '0);
      expect_state("R7 R8 disabled done ch7");
      // R7 error raises irq regardless of enable
      step(0, 8'h00, '0, '0, 16'h0080, 16'h0080);
      expect_state("R7 error ignores enable ch7");
      step(1, 8'h18, 32'hFFFF_FFFF, '0, '0, '0);
      step(1, 8'h08, 32'h0000_FFFF, '0, '0, '0);

      // R9 event wins over same-cycle clear
      step(0, 8'h00, '0, 16'h0002, '0, '0);
      step(1, 8'h08, 32'h0000_0002, 16'h0002, '0, '0);
      read_chk(8'h00, 32'hFF7F_0002, "R9 done ch1 survives clear");
      step(1, 8'h18, 32'h0000_0004, '0, 16'h0004, '0);
      read_chk(8'h10, 32'h0000_0004, "R9 term ch2 survives clear");
      expect_state("R9 state");

      // R4 plain write replaces register B
      step(1, 8'h10, 32'h0000_0040, '0, '0, '0);
      read_chk(8'h10, 32'h0000_0040, "R4 plain write reg B");
      expect_state("R4 R6 term ch6 after plain write");
      // R6 bus error alone is not an error
      step(1, 8'h14, 32'h0010_0000, '0, '0, '0);
      expect_state("R6 buserr without term ch4");
      // R5 unmapped address
      read_chk(8'h30, 32'h0, "R5 unmapped read");

      @(negedge clk);
      @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule